// File: doc/BRIEF.md
# Power sequence command engine

This block steps through a table of packed power-sequence entries and carries out each one on an 8-bit register bus. After a `start` pulse it fetches entries one at a time, beginning at index 0. It uses a request/valid handshake on a table-read port. Each entry carries three filter masks: silicon revision, fabrication site and host interface. Each mask is ANDed with a configuration input. An entry whose masks do not all overlap the configuration is passed over without any bus traffic.

The commands that execute are:

- a masked read;
- a read-modify-write that changes only the selected bits;
- a poll that re-reads a register until the masked data equals the masked value, giving up after a bounded number of attempts;
- a wait counted in microseconds or milliseconds from a clock prescaler;
- an end marker.

The block reports `busy`, `done` and `error`, the most recent masked read value, and the index of an entry whose poll timed out.

Top module: `pwrseq_engine`

## Requirements
- R1: A table entry is 56 bits wide: value [55:48], bit-mask [47:40], command code [39:36], register block selector [35:32], interface mask [31:28], fab mask [27:24], revision mask [23:16], offset [15:0].
- R2: An entry runs only if (revision mask & cfg_rev), (fab mask & cfg_fab) and (interface mask & cfg_intf) are all nonzero. Otherwise the next entry is fetched with no bus read or write.
- R3: Code 0 (read) makes exactly one bus read at the entry offset and sets last_rd to the read data ANDed with the bit-mask.
- R4: Code 1 (write) reads the register, then writes (old & ~mask) | (value & mask) to the same offset. bus_base carries the entry's block selector, and the write never overlaps a read.
- R5: Code 2 (poll) reads repeatedly until (data & mask) == (value & mask), then proceeds. last_rd holds the masked data of the final read.
- R6: If POLL_MAX poll reads in a row miss, the block raises error and records the entry index in fail_idx. It then stops fetching and stops all bus activity until the next start.
- R7: Code 3 with value bit 0 clear waits offset microseconds, where one microsecond is CLK_MHZ clock cycles. An offset of 0 adds no wait.
- R8: Code 3 with value bit 0 set waits offset milliseconds (1000 microsecond ticks each).
- R9: Code 4 ends the sequence: done goes high, busy goes low, and no further entries are fetched.
- R10: Command codes 5 to 15 are passed over with no bus access.
- R11: After reset, busy, done, error, tbl_req, bus_rd and bus_wr are low, and last_rd is 0.
- R12: tbl_req stays high with a stable tbl_idx until tbl_vld. Indices are fetched in order 0, 1, 2, and so on after each start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence at index 0 (ignored while busy) |
| cfg_rev | input | 8 | One-hot silicon revision of this die |
| cfg_fab | input | 4 | One-hot fabrication site |
| cfg_intf | input | 4 | One-hot host interface in use |
| tbl_req | output | 1 | Table entry requested |
| tbl_idx | output | IDX_W | Index of the requested entry |
| tbl_vld | input | 1 | Table entry present on tbl_entry |
| tbl_entry | input | 56 | Packed entry |
| bus_rd | output | 1 | Register read request |
| bus_wr | output | 1 | Register write request |
| bus_base | output | 4 | Register block selector |
| bus_addr | output | 16 | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer accepted this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End marker reached |
| error | output | 1 | Poll timed out |
| last_rd | output | 8 | Masked data of the latest read or poll |
| fail_idx | output | IDX_W | Index of the entry whose poll timed out |

## Verification
The hardest situation to reach from the ports is a poll that misses on some reads and then either matches or runs out of attempts. The bench's register model therefore answers one address with a counter that advances on every acknowledged read. A poll for value 3 then matches on exactly the fourth read. A poll for a value the counter never reaches must stop after exactly POLL_MAX reads. A read entry placed in front of it makes the recorded failing index nonzero. Millisecond waits are reached by building the engine with a small CLK_MHZ, so that a two-millisecond wait fits in a few thousand cycles.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int ENTRY_W = 56;
    localparam int US_PER_MS = 1000;

    localparam logic [3:0] OP_READ  = 4'd0;
    localparam logic [3:0] OP_WRITE = 4'd1;
    localparam logic [3:0] OP_POLL  = 4'd2;
    localparam logic [3:0] OP_WAIT  = 4'd3;
    localparam logic [3:0] OP_END   = 4'd4;

    typedef struct packed {
        logic [7:0]  value;
        logic [7:0]  bitmask;
        logic [3:0]  opcode;
        logic [3:0]  blk;
        logic [3:0]  intf_m;
        logic [3:0]  fab_m;
        logic [7:0]  rev_m;
        logic [15:0] offset;
    } entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_READ,
        S_WRITE,
        S_WAIT,
        S_DONE,
        S_FAIL
    } state_t;

    function automatic logic [7:0] merge_bits(input logic [7:0] old_v,
                                              input logic [7:0] msk,
                                              input logic [7:0] new_v);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

    function automatic logic masked_equal(input logic [7:0] data,
                                          input logic [7:0] msk,
                                          input logic [7:0] want);
        return (data & msk) == (want & msk);
    endfunction

    function automatic logic is_bus_op(input logic [3:0] op);
        return (op == OP_READ) || (op == OP_WRITE) || (op == OP_POLL);
    endfunction

endpackage

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
    parameter int CLK_MHZ = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic us_tick,
    output logic ms_tick
);
    localparam int US_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
    localparam int MS_W = $clog2(pwrseq_pkg::US_PER_MS);
    localparam logic [US_W-1:0] US_LAST = US_W'(CLK_MHZ - 1);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(pwrseq_pkg::US_PER_MS - 1);

    logic [US_W-1:0] us_cnt;
    logic [MS_W-1:0] ms_cnt;

    assign us_tick = (us_cnt == US_LAST);
    assign ms_tick = us_tick && (ms_cnt == MS_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            us_cnt <= '0;
            ms_cnt <= '0;
        end else begin
            us_cnt <= us_tick ? '0 : us_cnt + 1'b1;
            if (us_tick) begin
                ms_cnt <= ms_tick ? '0 : ms_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwrseq_filter.sv
module pwrseq_filter
    import pwrseq_pkg::*;
(
    input  entry_t     ent,
    input  logic [7:0] cfg_rev,
    input  logic [3:0] cfg_fab,
    input  logic [3:0] cfg_intf,
    output logic       applies
);
    logic [2:0] lane_ok;

    assign lane_ok[0] = |(ent.rev_m  & cfg_rev);
    assign lane_ok[1] = |(ent.fab_m  & cfg_fab);
    assign lane_ok[2] = |(ent.intf_m & cfg_intf);
    assign applies    = &lane_ok;
endmodule

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             unit_ms,
    input  logic             us_tick,
    input  logic             ms_tick,
    output logic             expire
);
    logic [CNT_W-1:0] remain;
    logic             unit_q;
    logic             step;

    assign step   = unit_q ? ms_tick : us_tick;
    assign expire = step && (remain == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            unit_q <= 1'b0;
        end else if (load) begin
            remain <= load_cnt;
            unit_q <= unit_ms;
        end else if (step && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/pwrseq_engine.sv
module pwrseq_engine
    import pwrseq_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int POLL_MAX = 64,
    parameter int IDX_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [7:0]           cfg_rev,
    input  logic [3:0]           cfg_fab,
    input  logic [3:0]           cfg_intf,
    output logic                 tbl_req,
    output logic [IDX_W-1:0]     tbl_idx,
    input  logic                 tbl_vld,
    input  logic [ENTRY_W-1:0]   tbl_entry,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic [3:0]           bus_base,
    output logic [15:0]          bus_addr,
    output logic [7:0]           bus_wdata,
    input  logic [7:0]           bus_rdata,
    input  logic                 bus_ack,
    output logic                 busy,
    output logic                 done,
    output logic                 error,
    output logic [7:0]           last_rd,
    output logic [IDX_W-1:0]     fail_idx
);
    localparam int ATT_W = $clog2(POLL_MAX + 1);
    localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(POLL_MAX - 1);

    state_t           state;
    entry_t           ent;
    logic [IDX_W-1:0] idx;
    logic [ATT_W-1:0] attempts;
    logic [7:0]       wdata_q;
    logic             applies;
    logic             us_tick, ms_tick;
    logic             wait_load;
    logic             wait_expire;
    logic             launch;

    pwrseq_filter u_filter (
        .ent      (ent),
        .cfg_rev  (cfg_rev),
        .cfg_fab  (cfg_fab),
        .cfg_intf (cfg_intf),
        .applies  (applies)
    );

    assign wait_load = (state == S_DECODE) && applies && (ent.opcode == OP_WAIT);

    pwrseq_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .clr     (wait_load),
        .us_tick (us_tick),
        .ms_tick (ms_tick)
    );

    pwrseq_delay #(.CNT_W(16)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_cnt (ent.offset),
        .unit_ms  (ent.value[0]),
        .us_tick  (us_tick),
        .ms_tick  (ms_tick),
        .expire   (wait_expire)
    );

    assign launch    = start && !busy;
    assign busy      = (state != S_IDLE) && (state != S_DONE) && (state != S_FAIL);
    assign done      = (state == S_DONE);
    assign error     = (state == S_FAIL);
    assign tbl_req   = (state == S_FETCH);
    assign tbl_idx   = idx;
    assign bus_rd    = (state == S_READ);
    assign bus_wr    = (state == S_WRITE);
    assign bus_base  = ent.blk;
    assign bus_addr  = ent.offset;
    assign bus_wdata = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            ent      <= '0;
            idx      <= '0;
            attempts <= '0;
            wdata_q  <= '0;
            last_rd  <= '0;
            fail_idx <= '0;
        end else begin
            case (state)
                S_IDLE, S_DONE, S_FAIL: begin
                    if (launch) begin
                        idx   <= '0;
                        state <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (tbl_vld) begin
                        ent   <= entry_t'(tbl_entry);
                        state <= S_DECODE;
                    end
                end
                S_DECODE: begin
                    attempts <= '0;
                    if (!applies) begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end else if (is_bus_op(ent.opcode)) begin
                        state <= S_READ;
                    end else if (ent.opcode == OP_WAIT) begin
                        if (ent.offset == '0) begin
                            idx   <= idx + 1'b1;
                            state <= S_FETCH;
                        end else begin
                            state <= S_WAIT;
                        end
                    end else if (ent.opcode == OP_END) begin
                        state <= S_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                S_READ: begin
                    if (bus_ack) begin
                        if (ent.opcode == OP_WRITE) begin
                            wdata_q <= merge_bits(bus_rdata, ent.bitmask, ent.value);
                            state   <= S_WRITE;
                        end else begin
                            last_rd <= bus_rdata & ent.bitmask;
                            if (ent.opcode == OP_READ ||
                                masked_equal(bus_rdata, ent.bitmask, ent.value)) begin
                                idx   <= idx + 1'b1;
                                state <= S_FETCH;
                            end else if (attempts == ATT_LAST) begin
                                fail_idx <= idx;
                                state    <= S_FAIL;
                            end else begin
                                attempts <= attempts + 1'b1;
                            end
                        end
                    end
                end
                S_WRITE: begin
                    if (bus_ack) begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                S_WAIT: begin
                    if (wait_expire) begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwrseq_engine_chk.sv
module pwrseq_engine_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             tbl_req,
    input logic             tbl_vld,
    input logic [IDX_W-1:0] tbl_idx,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_ack,
    input logic [15:0]      bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             busy,
    input logic             done,
    input logic             error
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R4

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr) |-> $past(bus_rd && bus_ack)); // R4

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_ack |=> bus_wr && $stable(bus_wdata) && $stable(bus_addr)); // R4

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_rd && !bus_ack |=> bus_rd && $stable(bus_addr)); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        tbl_req && !tbl_vld |=> tbl_req && $stable(tbl_idx)); // R12

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({busy, done, error}) <= 1); // R9

    AST_ERR_HALT: assert property (@(posedge clk) disable iff (rst)
        error |-> !tbl_req && !bus_rd && !bus_wr); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        error && !start |=> error); // R6

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tbl_req && !bus_rd && !bus_wr); // R11
endmodule

bind pwrseq_engine pwrseq_engine_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tbl_req   (tbl_req),
    .tbl_vld   (tbl_vld),
    .tbl_idx   (tbl_idx),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (done),
    .error     (error)
);

// File: tb/pwrseq_engine_tb.sv
module pwrseq_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ   = 2;
    localparam int PMAX  = 6;
    localparam int IW    = 4;

    // write vectors: {initial reg, bit-mask, value, expected reg}
    localparam logic [31:0] WVEC [6] = '{
        32'hA5_0F_3C_AC, 32'h00_FF_5A_5A, 32'hFF_00_00_FF,
        32'h3C_C3_FF_FF, 32'h81_7E_24_A5, 32'hF0_3C_0F_CC
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] cfg_rev = 8'h04;
    logic [3:0] cfg_fab = 4'h1;
    logic [3:0] cfg_intf = 4'h2;
    logic tbl_req, tbl_vld;
    logic [IW-1:0] tbl_idx;
    logic [55:0] tbl_entry;
    logic bus_rd, bus_wr, bus_ack;
    logic [3:0] bus_base;
    logic [15:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic busy, done, error;
    logic [7:0] last_rd;
    logic [IW-1:0] fail_idx;

    logic [55:0] tbl [16];
    logic [7:0] regs [16];
    logic [7:0] pollcnt;
    int rd_cnt, wr_cnt, fetch_cnt, seq_err;
    logic [3:0] wr_base;
    logic [IW-1:0] exp_idx;
    logic clr_stats = 1'b0;
    logic ld_en = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_val = '0;
    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrseq_engine #(.CLK_MHZ(MHZ), .POLL_MAX(PMAX), .IDX_W(IW)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_rev(cfg_rev), .cfg_fab(cfg_fab), .cfg_intf(cfg_intf),
        .tbl_req(tbl_req), .tbl_idx(tbl_idx), .tbl_vld(tbl_vld), .tbl_entry(tbl_entry),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_base(bus_base), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .done(done), .error(error), .last_rd(last_rd), .fail_idx(fail_idx)
    );

    assign tbl_vld   = tbl_req;
    assign tbl_entry = tbl[tbl_idx];
    assign bus_ack   = bus_rd | bus_wr;
    assign bus_rdata = (bus_addr[3:0] == 4'hF) ? pollcnt : regs[bus_addr[3:0]];

    always @(posedge clk) begin
        if (clr_stats) begin
            rd_cnt <= 0; wr_cnt <= 0; fetch_cnt <= 0; seq_err <= 0;
            pollcnt <= '0; exp_idx <= '0; wr_base <= '0;
        end else begin
            if (bus_rd && bus_ack) begin
                rd_cnt <= rd_cnt + 1;
                if (bus_addr[3:0] == 4'hF) pollcnt <= pollcnt + 8'd1;
            end
            if (bus_wr && bus_ack) begin
                wr_cnt <= wr_cnt + 1;
                wr_base <= bus_base;
            end
            if (tbl_req && tbl_vld) begin
                fetch_cnt <= fetch_cnt + 1;
                if (tbl_idx != exp_idx) seq_err <= seq_err + 1;
                exp_idx <= exp_idx + 1'b1;
            end
        end
        if (ld_en) regs[ld_addr] <= ld_val;
        else if (bus_wr && bus_ack) regs[bus_addr[3:0]] <= bus_wdata;
    end

    function automatic logic [55:0] mk(input logic [3:0] op, input logic [3:0] blk,
                                       input logic [15:0] off, input logic [7:0] msk,
                                       input logic [7:0] val, input logic [7:0] rv,
                                       input logic [3:0] fb, input logic [3:0] it);
        return {val, msk, op, blk, it, fb, rv, off};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_table();
        for (int i = 0; i < 16; i++) tbl[i] = mk(4'd4, 4'd0, 16'd0, 8'd0, 8'd0, 8'hFF, 4'hF, 4'hF);
    endtask

    task automatic set_reg(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); ld_en = 1'b1; ld_addr = a; ld_val = v;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic run_seq(output int cyc);
        @(negedge clk); clr_stats = 1'b1;
        @(negedge clk); clr_stats = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!(done || error) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        for (int i = 0; i < 16; i++) regs[i] = 8'h00;
        clear_table();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !error && !tbl_req && !bus_rd && !bus_wr && last_rd == 8'h00,
            "R11 reset", {busy, done, error, tbl_req, bus_rd, bus_wr}, 0);

        // R4 R1 vector walk: read-modify-write then read back
        for (int v = 0; v < 6; v++) begin
            set_reg(4'd2, WVEC[v][31:24]);
            clear_table();
            tbl[0] = mk(4'd1, 4'd1, 16'd2, WVEC[v][23:16], WVEC[v][15:8], 8'hFF, 4'hF, 4'hF);
            tbl[1] = mk(4'd0, 4'd0, 16'd2, 8'hFF, 8'h00, 8'hFF, 4'hF, 4'hF);
            run_seq(cyc);
            chk(regs[2] == WVEC[v][7:0], "R4 merged reg", regs[2], WVEC[v][7:0]);
            chk(last_rd == WVEC[v][7:0], "R3 readback", last_rd, WVEC[v][7:0]);
            chk(rd_cnt == 2 && wr_cnt == 1, "R4 access count", rd_cnt*16+wr_cnt, 33);
            chk(wr_base == 4'd1, "R1 R4 block select", wr_base, 1);
            chk(done && !busy && fetch_cnt == 3 && seq_err == 0, "R9 R12 end", fetch_cnt, 3);
        end

        // R3 masked read
        set_reg(4'd3, 8'hF5);
        clear_table();
        tbl[0] = mk(4'd0, 4'd2, 16'd3, 8'h3C, 8'h00, 8'hFF, 4'hF, 4'hF);
        run_seq(cyc);
        chk(last_rd == 8'h34 && rd_cnt == 1, "R3 masked read", last_rd, 8'h34);

        // R2 filtering by revision, fab, interface
        set_reg(4'd4, 8'h5C);
        clear_table();
        tbl[0] = mk(4'd1, 4'd0, 16'd4, 8'hFF, 8'h77, 8'h02, 4'hF, 4'hF);
        tbl[1] = mk(4'd1, 4'd0, 16'd4, 8'hFF, 8'h11, 8'hFF, 4'h2, 4'hF);
        tbl[2] = mk(4'd1, 4'd0, 16'd4, 8'hFF, 8'h22, 8'hFF, 4'hF, 4'h4);
        tbl[3] = mk(4'd0, 4'd0, 16'd4, 8'hFF, 8'h00, 8'h04, 4'h1, 4'h2);
        run_seq(cyc);
        chk(wr_cnt == 0 && regs[4] == 8'h5C, "R2 skipped writes", regs[4], 8'h5C);
        chk(rd_cnt == 1 && last_rd == 8'h5C, "R2 matching entry runs", last_rd, 8'h5C);
        chk(fetch_cnt == 5 && seq_err == 0, "R12 fetch order", fetch_cnt, 5);

        // R10 undefined command codes
        clear_table();
        tbl[0] = mk(4'd9, 4'd0, 16'd4, 8'hFF, 8'h00, 8'hFF, 4'hF, 4'hF);
        tbl[1] = mk(4'd15, 4'd0, 16'd4, 8'hFF, 8'h00, 8'hFF, 4'hF, 4'hF);
        run_seq(cyc);
        chk(rd_cnt == 0 && wr_cnt == 0 && done && fetch_cnt == 3, "R10 no bus", rd_cnt+wr_cnt, 0);

        // R5 poll success on fourth read
        clear_table();
        tbl[0] = mk(4'd2, 4'd0, 16'hF, 8'h0F, 8'h03, 8'hFF, 4'hF, 4'hF);
        run_seq(cyc);
        chk(done && rd_cnt == 4 && last_rd == 8'h03, "R5 poll match", rd_cnt, 4);

        // R6 poll timeout
        clear_table();
        tbl[0] = mk(4'd0, 4'd0, 16'd3, 8'hFF, 8'h00, 8'hFF, 4'hF, 4'hF);
        tbl[1] = mk(4'd2, 4'd0, 16'hF, 8'hFF, 8'hEE, 8'hFF, 4'hF, 4'hF);
        run_seq(cyc);
        chk(error && !done && !busy, "R6 error flag", {error, done, busy}, 3'b100);
        chk(fail_idx == 4'd1, "R6 failing index", fail_idx, 1);
        chk(rd_cnt == 1 + PMAX, "R6 attempt count", rd_cnt, 1 + PMAX);
        repeat (20) @(negedge clk);
        chk(fetch_cnt == 2 && rd_cnt == 1 + PMAX && error, "R6 halted", fetch_cnt, 2);

        // R7 microsecond wait
        clear_table();
        tbl[0] = mk(4'd3, 4'd0, 16'd5, 8'h00, 8'h00, 8'hFF, 4'hF, 4'hF);
        run_seq(cyc);
        chk(done && cyc >= 5*MHZ && cyc <= 5*MHZ + 10, "R7 us wait", cyc, 5*MHZ);

        // R7 zero-length wait
        clear_table();
        tbl[0] = mk(4'd3, 4'd0, 16'd0, 8'h00, 8'h01, 8'hFF, 4'hF, 4'hF);
        run_seq(cyc);
        chk(done && cyc <= 10, "R7 zero wait", cyc, 6);

        // R8 millisecond wait
        clear_table();
        tbl[0] = mk(4'd3, 4'd0, 16'd2, 8'h00, 8'h01, 8'hFF, 4'hF, 4'hF);
        run_seq(cyc);
        chk(done && cyc >= 2000*MHZ && cyc <= 2000*MHZ + 10, "R8 ms wait", cyc, 2000*MHZ);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule